// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a small two-way set-associative data cache with a write-back policy. It sits between a processor-side request port and a word-addressed main-memory port. A processor request carries a valid flag, a write enable, a word address and write data. The cache answers with read data and a ready strobe. Lines that miss are moved one word at a time over a request/acknowledge memory port. Each line holds four words. There are eight sets. The word address splits, from the top, into a tag, a 3-bit set index at bits [4:2] and a 2-bit word offset at bits [1:0].

Each way of each set keeps a tag, a valid flag and a dirty flag. Each set also keeps one recency bit that names the way used last. A read or write that hits is served combinationally, in the cycle it is presented. On a miss, a victim is chosen. If the victim holds modified data, it is first copied back to memory. The missing line is then fetched. The request is served from the cache in the next cycle, and a write is merged into the fetched line at that point. A flush input drops every line at once. It writes nothing back, so modified data in the cache is lost on a flush.

Requests follow a hold-until-ready protocol: address, write enable and data stay stable while valid is high and ready is low.

Top module: `wbc_cache_top`

## Requirements
- R1: An access hits only when a way of the indexed set is valid and its stored tag equals the address tag. After reset, the first access to any line misses and fetches from memory.
- R2: Reset and the flush input both clear every valid flag. The first access to any line after a flush misses. `req_ready` is low in every cycle that `flush` is high.
- R3: A read miss fetches the four words of the line at addresses {tag, index, 0..3}, in increasing offset order. It installs the line as valid and clean and returns the addressed word.
- R4: A write hit updates the cached word and marks the line dirty. It completes in the cycle it is presented and does not write main memory.
- R5: On a miss, the victim is written back to {stored tag, index, 0..3}, in increasing offset order, only if it is valid and dirty. A clean or invalid victim causes no memory write.
- R6: A write miss first fetches the whole line, then merges the written word and marks the line dirty. The other three words keep their memory values, and main memory is not written by the request itself.
- R7: With both ways valid, a miss replaces the way not accessed most recently. After a fill, the recency bit names the filled way. After a hit, it names the hit way.
- R8: An invalid way is chosen as victim before the recency bit is consulted, with way 0 preferred over way 1.
- R9: `req_ready` stays low while write-back or refill is in progress. A missing request completes in the cycle right after the last refill word is accepted.
- R10: A flush does not write back dirty lines: memory keeps its old contents, and a later read returns the memory value rather than the discarded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines, no write-back |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, index, offset} |
| req_wdata | input | DATA_W | Write data |
| req_rdata | output | DATA_W | Read data, valid while req_ready is high |
| req_ready | output | 1 | Request completes in this cycle |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Refill data, sampled with mem_ack |
| mem_ack | input | 1 | Current memory word transferred |

## Verification
The bench builds the block with its default parameters: 12-bit word addresses, 32-bit data, eight sets and four-word lines. This is small enough for every set to be driven through the full sequence: cold miss, hits on each offset, a write hit, a fill of the empty second way, a dirty eviction, a clean eviction, a write-allocate miss and a flush. The expected data are simple arithmetic functions of the address. A behavioural memory logs the order of refill and write-back addresses, and it counts the words moved in each direction. From those counts the bench infers hit, clean miss or dirty miss for every access.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-way write-back cache controller.
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,   // serve hits, detect misses
        ST_WBACK = 2'd1,   // copy dirty victim to memory
        ST_FILL  = 2'd2    // fetch missing line from memory
    } ctl_state_t;
endpackage

// File: rtl/wbc_tag_store.sv
`timescale 1ns/1ps
// Tag, valid, dirty and recency storage for a two-way cache.
// Does: compares the lookup tag against both ways of the indexed set, picks
// a victim (invalid way first, way 0 preferred, else the least recent way),
// and applies hit, fill and flush updates.
// Assumes: access and fill are never requested in the same cycle; flush wins
// over a fill in the same cycle.
module wbc_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             acc_en,
    input  logic             acc_way,
    input  logic             acc_dirty,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]          tag_q [2][SETS];
    logic [1:0][SETS-1:0]      val_q;
    logic [1:0][SETS-1:0]      dirty_q;
    logic [SETS-1:0]           lru_q;
    logic [1:0]                match;

    // Per-way tag comparison gated by the valid flag.
    generate
        for (genvar w = 0; w < 2; w++) begin : g_way
            assign match[w] = val_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
        end
    endgenerate

    // Hit detection and victim selection.
    always_comb begin
        hit     = |match;
        hit_way = match[1];
        if (!val_q[0][lk_idx])      vic_way = 1'b0;
        else if (!val_q[1][lk_idx]) vic_way = 1'b1;
        else                        vic_way = ~lru_q[lk_idx];
        vic_dirty = val_q[vic_way][lk_idx] && dirty_q[vic_way][lk_idx];
        vic_tag   = tag_q[vic_way][lk_idx];
    end

    // Tag write on fill; tags need no reset because valid gates them.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_way][lk_idx] <= fill_tag;
    end

    // Valid flags: cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  val_q <= '0;
        else if (fill_en)     val_q[fill_way][lk_idx] <= 1'b1;
    end

    // Dirty flags: cleared by a fill, set by a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dirty_q <= '0;
        else if (fill_en)             dirty_q[fill_way][lk_idx] <= 1'b0;
        else if (acc_en && acc_dirty) dirty_q[acc_way][lk_idx]  <= 1'b1;
    end

    // Recency bit: names the way touched last.
    always_ff @(posedge clk) begin
        if (!rst_n)       lru_q <= '0;
        else if (fill_en) lru_q[lk_idx] <= fill_way;
        else if (acc_en)  lru_q[lk_idx] <= acc_way;
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (val_q == '0)) else $error("flush left a valid line"); // R2
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (val_q[$past(fill_way)][$past(lk_idx)] && !dirty_q[$past(fill_way)][$past(lk_idx)]))
        else $error("filled line not valid and clean"); // R3
    AST_RECENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en || fill_en) |=> (lru_q[$past(lk_idx)] == $past(fill_en ? fill_way : acc_way)))
        else $error("recency bit not updated"); // R7
endmodule

// File: rtl/wbc_data_store.sv
`timescale 1ns/1ps
// Line data storage for a two-way cache: one write port, one asynchronous
// read port, addressed by {way, set, word}.
// Assumes: contents are undefined after reset; valid flags gate their use.
module wbc_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 2 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Word write.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_way, wr_idx, wr_off}] <= wr_data;
    end

    // Combinational word read.
    assign rd_data = mem_q[{rd_way, rd_idx, rd_off}];
endmodule

// File: rtl/wbc_ctrl.sv
`timescale 1ns/1ps
// Cache sequencer: serves hits in the lookup state, and on a miss copies a
// dirty victim back and then refills the line word by word.
// Assumes: the request stays stable while valid is high and ready is low;
// memory accepts one word per cycle in which mem_ack is high.
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hit,
    input  logic              hit_way,
    input  logic              vic_way,
    input  logic              vic_dirty,
    input  logic [TAG_W-1:0]  vic_tag,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              req_ready,
    output logic              acc_en,
    output logic              fill_en,
    output logic              fill_way,
    output logic              dwr_en,
    output logic              dwr_way,
    output logic [OFF_W-1:0]  dwr_off,
    output logic [DATA_W-1:0] dwr_data,
    output logic              rd_way,
    output logic [OFF_W-1:0]  rd_off,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    ctl_state_t       state_q;
    logic [OFF_W-1:0] cnt_q;
    logic             way_q;
    logic [TAG_W-1:0] vtag_q;
    logic [TAG_W-1:0] r_tag;
    logic [IDX_W-1:0] r_idx;
    logic [OFF_W-1:0] r_off;
    logic             lookup_go;
    logic             last;

    // Request field split and handshake outputs.
    always_comb begin
        r_tag     = req_addr[ADDR_W-1 -: TAG_W];
        r_idx     = req_addr[OFF_W +: IDX_W];
        r_off     = req_addr[OFF_W-1:0];
        last      = (cnt_q == '1);
        lookup_go = (state_q == ST_LOOK) && req_valid && !flush;
        req_ready = lookup_go && hit;
        acc_en    = req_ready;
        fill_en   = (state_q == ST_FILL) && mem_ack && last;
        fill_way  = way_q;
    end

    // Memory port and data-store steering.
    always_comb begin
        mem_req  = (state_q != ST_LOOK);
        mem_we   = (state_q == ST_WBACK);
        mem_addr = (state_q == ST_WBACK) ? {vtag_q, r_idx, cnt_q} : {r_tag, r_idx, cnt_q};
        dwr_en   = ((state_q == ST_FILL) && mem_ack) || (req_ready && req_we);
        dwr_way  = (state_q == ST_FILL) ? way_q     : hit_way;
        dwr_off  = (state_q == ST_FILL) ? cnt_q     : r_off;
        dwr_data = (state_q == ST_FILL) ? mem_rdata : req_wdata;
        rd_way   = (state_q == ST_WBACK) ? way_q : hit_way;
        rd_off   = (state_q == ST_WBACK) ? cnt_q : r_off;
    end

    // Sequencer state, word counter and latched victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOK;
            cnt_q   <= '0;
            way_q   <= 1'b0;
            vtag_q  <= '0;
        end else begin
            case (state_q)
                ST_LOOK: if (lookup_go && !hit) begin
                    way_q   <= vic_way;
                    vtag_q  <= vic_tag;
                    cnt_q   <= '0;
                    state_q <= vic_dirty ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) state_q <= ST_LOOK;
                end
                default: state_q <= ST_LOOK;
            endcase
        end
    end

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_go && !hit) |=> (mem_req && !req_ready)) else $error("miss did not stall"); // R9
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK && $past(state_q) == ST_LOOK) |-> $past(vic_dirty))
        else $error("write-back of a clean victim"); // R5
    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack && !last) |=> (mem_addr == $past(mem_addr) + 1'b1))
        else $error("refill words out of order"); // R3
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !flush) |=> (req_valid && $stable(req_addr) && $stable(req_we)))
        else $error("request changed while stalled"); // R9
endmodule

// File: rtl/wbc_cache_top.sv
`timescale 1ns/1ps
// Two-way set-associative write-back data cache.
// Does: connects the tag store, data store and sequencer; hits complete in
// the cycle presented, misses write back a dirty victim and refill a line.
// Assumes: hold-until-ready request protocol; flush discards dirty data.
module wbc_cache_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              req_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic              hit, hit_way, vic_way, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              acc_en, fill_en, fill_way;
    logic              dwr_en, dwr_way, rd_way;
    logic [OFF_W-1:0]  dwr_off, rd_off;
    logic [DATA_W-1:0] dwr_data, rd_data;

    // Address fields shared by both stores.
    assign r_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign r_idx     = req_addr[OFF_W +: IDX_W];
    assign req_rdata = rd_data;
    assign mem_wdata = rd_data;

    wbc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_idx(r_idx), .lk_tag(r_tag),
        .acc_en(acc_en), .acc_way(hit_way), .acc_dirty(req_we),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(r_tag),
        .hit(hit), .hit_way(hit_way), .vic_way(vic_way),
        .vic_dirty(vic_dirty), .vic_tag(vic_tag)
    );

    wbc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk(clk), .wr_en(dwr_en), .wr_way(dwr_way), .wr_idx(r_idx),
        .wr_off(dwr_off), .wr_data(dwr_data),
        .rd_way(rd_way), .rd_idx(r_idx), .rd_off(rd_off), .rd_data(rd_data)
    );

    wbc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
               .OFF_W(OFF_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .hit(hit), .hit_way(hit_way),
        .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .req_ready(req_ready), .acc_en(acc_en), .fill_en(fill_en),
        .fill_way(fill_way), .dwr_en(dwr_en), .dwr_way(dwr_way),
        .dwr_off(dwr_off), .dwr_data(dwr_data), .rd_way(rd_way),
        .rd_off(rd_off), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr)
    );
endmodule

// File: tb/wbc_cache_top_test.sv
`timescale 1ns/1ps
// Bench: sweeps every set through miss, hit, write, eviction and flush
// sequences against a behavioural word memory.
module wbc_cache_top_test;
    localparam int T1 = 7'h11, T2 = 7'h22, T3 = 7'h33, T4 = 7'h44, T5 = 7'h55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        req_ready;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic [31:0] mem [4096];
    logic [11:0] rd_log [16];
    logic [11:0] wr_log [16];
    int rd_cnt = 0, wr_cnt = 0, rd0, wr0, drd, dwr, cyc, last_busy;
    int checks = 0, errors = 0;
    logic [31:0] got;

    wbc_cache_top uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .req_ready(req_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] mk(input int t, input int s, input int o);
        logic [6:0] tt = t[6:0];
        logic [2:0] ss = s[2:0];
        logic [1:0] oo = o[1:0];
        return {tt, ss, oo};
    endfunction
    function automatic logic [31:0] pat(input logic [11:0] a);
        return 32'hC0DE0000 | {20'h0, a};
    endfunction
    function automatic logic [31:0] wv(input logic [11:0] a);
        return 32'h5EED0000 | {20'h0, a};
    endfunction

    // Behavioural memory: one word per acknowledge, ack dropped for a cycle between words.
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (rst_n && mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_log[wr_cnt % 16] = mem_addr;
                wr_cnt++;
            end else begin
                mem_rdata = mem[mem_addr];
                rd_log[rd_cnt % 16] = mem_addr;
                rd_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One processor access, held until ready; records latency and memory traffic.
    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        cyc = 0; last_busy = -1;
        #1;
        while (!req_ready && cyc < 500) begin
            if (mem_req) last_busy = cyc;
            @(negedge clk); #1; cyc++;
        end
        got = req_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0; req_we = 1'b0;
        drd = rd_cnt - rd0; dwr = wr_cnt - wr0;
    endtask

    task automatic expect_hit(input string tag);
        chk({tag, " hit latency"}, cyc, 0);
        chk({tag, " hit no mem reads"}, drd, 0);
        chk({tag, " hit no mem writes"}, dwr, 0);
    endtask

    task automatic expect_miss(input string tag, input int writes);
        chk({tag, " miss reads"}, drd, 4);
        chk({tag, " miss writes"}, dwr, writes);
        chk("R9 ready right after install", cyc, last_busy + 1);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = pat(a[11:0]);
        repeat (4) @(posedge clk);
        #1;
        chk("R2 reset ready low", req_ready, 0);
        chk("R2 reset no mem request", mem_req, 0);
        rst_n = 1'b1;

        // R1 R3 R8: cold misses fill way 0 of every set, in offset order.
        for (int s = 0; s < 8; s++) begin
            access(1'b0, mk(T1, s, s % 4), '0);
            chk("R1 cold read data", got, pat(mk(T1, s, s % 4)));
            expect_miss("R1", 0);
            for (int k = 0; k < 4; k++)
                chk("R3 refill order", rd_log[(rd0 + k) % 16], mk(T1, s, k));
            for (int o = 0; o < 4; o++) begin
                access(1'b0, mk(T1, s, o), '0);
                chk("R3 installed word", got, pat(mk(T1, s, o)));
                expect_hit("R3");
            end
        end

        // R4: write hits stay in the cache.
        for (int s = 0; s < 8; s++) begin
            access(1'b1, mk(T1, s, 1), wv(mk(T1, s, 1)));
            expect_hit("R4 write");
            chk("R4 memory untouched", mem[mk(T1, s, 1)], pat(mk(T1, s, 1)));
            access(1'b0, mk(T1, s, 1), '0);
            chk("R4 read back", got, wv(mk(T1, s, 1)));
        end

        // R8: empty way 1 taken before dirty way 0; then make T1 least recent.
        for (int s = 0; s < 8; s++) begin
            access(1'b0, mk(T2, s, 0), '0);
            chk("R8 data", got, pat(mk(T2, s, 0)));
            expect_miss("R8 invalid way first", 0);
            access(1'b0, mk(T1, s, 1), '0);
            chk("R8 way 0 kept", got, wv(mk(T1, s, 1)));
            expect_hit("R8");
            access(1'b0, mk(T2, s, 2), '0);
            expect_hit("R7 touch");
        end

        // R5 R7: dirty least-recent victim is written back; clean one is not.
        for (int s = 0; s < 8; s++) begin
            access(1'b0, mk(T3, s, 0), '0);
            chk("R5 data", got, pat(mk(T3, s, 0)));
            expect_miss("R5 dirty victim", 4);
            for (int k = 0; k < 4; k++)
                chk("R5 write-back address", wr_log[(wr0 + k) % 16], mk(T1, s, k));
            chk("R5 written word in memory", mem[mk(T1, s, 1)], wv(mk(T1, s, 1)));
            chk("R5 other word in memory", mem[mk(T1, s, 3)], pat(mk(T1, s, 3)));
            access(1'b0, mk(T2, s, 3), '0);
            expect_hit("R7 recent way kept");
            access(1'b0, mk(T4, s, 0), '0);
            expect_miss("R7 clean victim", 0);
            access(1'b0, mk(T2, s, 0), '0);
            expect_hit("R7 recent way kept again");
            access(1'b0, mk(T3, s, 0), '0);
            expect_miss("R7 evicted line", 0);
        end

        // R6: write miss allocates, merges, and is written back later.
        for (int s = 0; s < 8; s++) begin
            access(1'b1, mk(T5, s, 2), 32'hFACE0000 | s);
            expect_miss("R6 write miss", 0);
            chk("R6 memory not written", mem[mk(T5, s, 2)], pat(mk(T5, s, 2)));
            access(1'b0, mk(T5, s, 2), '0);
            chk("R6 merged word", got, 32'hFACE0000 | s);
            expect_hit("R6");
            access(1'b0, mk(T5, s, 0), '0);
            chk("R6 fetched word", got, pat(mk(T5, s, 0)));
            access(1'b0, mk(T1, s, 0), '0);
            expect_miss("R6 clean eviction", 0);
            access(1'b0, mk(T2, s, 0), '0);
            expect_miss("R6 dirty eviction", 4);
            chk("R6 merged word in memory", mem[mk(T5, s, 2)], 32'hFACE0000 | s);
            chk("R6 fetched word in memory", mem[mk(T5, s, 0)], pat(mk(T5, s, 0)));
        end

        // R2 R10: dirty write, then flush; nothing is written back.
        access(1'b1, mk(T1, 0, 3), 32'hDEAD0003);
        expect_hit("R10 write before flush");
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        flush = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_addr = mk(T2, 0, 0);
        #1;
        chk("R2 ready low during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        cyc = 0; last_busy = -1;
        #1;
        while (!req_ready && cyc < 500) begin
            if (mem_req) last_busy = cyc;
            @(negedge clk); #1; cyc++;
        end
        chk("R2 flushed line data", req_rdata, pat(mk(T2, 0, 0)));
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R2 flushed line refetched", rd_cnt - rd0, 4);
        chk("R10 no write-back on flush", wr_cnt - wr0, 0);
        for (int s = 1; s < 8; s++) begin
            access(1'b0, mk(T2, s, 0), '0);
            expect_miss("R2 after flush", 0);
        end
        access(1'b0, mk(T1, 0, 3), '0);
        expect_miss("R10 discarded line", 0);
        chk("R10 memory keeps old value", mem[mk(T1, 0, 3)], pat(mk(T1, 0, 3)));
        chk("R10 read returns memory value", got, pat(mk(T1, 0, 3)));

        finish_run();
    end
endmodule